// File: doc/BRIEF.md
# UART register and interrupt front end

This block is the software-facing side of a serial port. A 32-bit register bus with byte offsets reaches a set of word-aligned registers. Writing the data register loads a 16-entry transmit FIFO and reading it unloads a 16-entry receive FIFO. The serializer and deserializer are outside this block and connect through plain push, pop and status pins. They receive the programmed character format, the baud divisor, the enable and the loopback settings from this block.

Error conditions reported by the deserializer are collected in a sticky status register. Any write to that register clears it. Four interrupt sources are latched into an identification register, and any latched bit drives the single interrupt line. The sources are a change of the modem CTS line, receive FIFO occupancy reaching a programmable threshold, transmit FIFO occupancy falling to a programmable threshold, and a receive timeout pulse. Writing zero to the identification register clears the latched sources.

Word offsets decoded from address bits 5:2: 0x00 data, 0x04 receive status, 0x08 line format, 0x0C divisor high byte, 0x10 divisor low byte, 0x14 control, 0x18 flags, 0x1C interrupt identification, 0x38 receive threshold, 0x3C transmit threshold. Other offsets read as zero and ignore writes. Read data is registered and appears on `busRdata` in the cycle after the access.

Top module: `uart_regif`

## Requirements
- R1: After reset every stored register is zero and `irq` is low. A read of the flags register then returns 0x90, which means both FIFOs are empty and all other flags are clear.
- R2: A data register write with the transmit FIFO not full stores `busWdata[7:0]` in order. `txData` shows the oldest entry while `txEmpty` is low, and `txPop` removes it. A write when 16 entries are held is ignored.
- R3: A data register read returns the oldest received byte and removes it. A read with the receive FIFO empty returns zero and removes nothing. An `rxPush` adds `rxData` when fewer than 16 entries are held.
- R4: The receive status register is sticky, and any write to it clears all four bits. On an `rxPush` it sets bit0 from `rxErr[0]` (framing), bit1 from `rxErr[1]` (parity) and bit2 from `rxErr[2]` (break). Bit3 (overrun) is set by an `rxPush` arriving while the receive FIFO is full, and that byte is dropped.
- R5: The line format register keeps bits 6:0 and drives them on `lineCfg`. These are bit0 send break, bit1 parity enable, bit2 even parity, bit3 two stop bits, bit4 FIFO enable and bits 6:5 word length. `baudDiv` is {high byte, low byte}. The control register keeps bits 0 and 7:3, while bits 2:1 read as zero. Bit0 drives `uartEn` and bit7 drives `loopback`.
- R6: The flags register reads as follows: bit0 CTS, bit1 DSR, bit2 DCD, bit3 busy, bit4 receive FIFO empty, bit5 transmit FIFO full, bit6 receive FIFO full and bit7 transmit FIFO empty. The three modem lines are seen through a two-stage synchroniser.
- R7: Identification bit1 latches when the receive FIFO count is at or above the receive threshold while control bit4 is set.
- R8: Identification bit2 latches when the transmit FIFO count is at or below the transmit threshold while control bit5 is set.
- R9: Identification bit0 latches on any change of the synchronised CTS line while control bit3 is set.
- R10: Identification bit3 latches on an `rxTimeout` pulse while control bit6 is set.
- R11: A write of zero to the identification register clears every latched bit. The clear wins over a set in the same cycle. A nonzero write has no effect. `irq` is high exactly while any latched bit is set.
- R12: The busy flag is set while the transmit FIFO holds data or `txShifting` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| txData | output | 8 | Oldest transmit FIFO entry |
| txEmpty | output | 1 | Transmit FIFO empty |
| txPop | input | 1 | Serializer takes the oldest entry |
| txShifting | input | 1 | Serializer is sending a character |
| rxData | input | 8 | Received character |
| rxPush | input | 1 | Received character valid |
| rxErr | input | 3 | Framing, parity, break flags of the character |
| rxTimeout | input | 1 | Receive timeout pulse |
| ctsIn | input | 1 | Asynchronous CTS line |
| dsrIn | input | 1 | Asynchronous DSR line |
| dcdIn | input | 1 | Asynchronous DCD line |
| lineCfg | output | 7 | Character format to the serializer |
| baudDiv | output | 16 | Baud divisor |
| uartEn | output | 1 | Port enable |
| loopback | output | 1 | Loopback select |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume the serializer pops only through `txPop` and the deserializer pushes only through `rxPush`, one entry per cycle at most. The properties also assume that the register bus performs no more than one access per cycle. The stimulus meets these assumptions by driving every input from tasks on the falling clock edge and by holding `busSel` for exactly one cycle per access. The modem lines change only with long stable gaps, so the synchroniser always settles before the next change. No status clear is issued in the same cycle as an `rxPush`.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  typedef enum logic [3:0] {
    SEL_DATA,
    SEL_STAT,
    SEL_LINE,
    SEL_BAUDH,
    SEL_BAUDL,
    SEL_CTRL,
    SEL_FLAG,
    SEL_IIR,
    SEL_RXLVL,
    SEL_TXLVL,
    SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    wr;
    logic    rd;
    regSel_e sel;
  } busStrobe_t;

  // control register bit positions
  localparam int CTRL_EN   = 0;
  localparam int CTRL_MSIE = 3;
  localparam int CTRL_RXIE = 4;
  localparam int CTRL_TXIE = 5;
  localparam int CTRL_TOIE = 6;
  localparam int CTRL_LOOP = 7;

  // interrupt identification bit positions
  localparam int IRQ_MODEM = 0;
  localparam int IRQ_RX    = 1;
  localparam int IRQ_TX    = 2;
  localparam int IRQ_TOUT  = 3;

endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;
  logic             doPush;
  logic             doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_regif_ctrl.sv
module uart_regif_ctrl
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int WW = ADDR_W - 2
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe,
  output logic              txPushReq,
  output logic              rxPopReq
);

  logic [WW-1:0] word;
  regSel_e       sel;

  assign word = busAddr[ADDR_W-1:2];

  always_comb begin
    case (word)
      WW'(0):  sel = SEL_DATA;
      WW'(1):  sel = SEL_STAT;
      WW'(2):  sel = SEL_LINE;
      WW'(3):  sel = SEL_BAUDH;
      WW'(4):  sel = SEL_BAUDL;
      WW'(5):  sel = SEL_CTRL;
      WW'(6):  sel = SEL_FLAG;
      WW'(7):  sel = SEL_IIR;
      WW'(14): sel = SEL_RXLVL;
      WW'(15): sel = SEL_TXLVL;
      default: sel = SEL_NONE;
    endcase
  end

  assign strobe.wr  = busSel && busWr;
  assign strobe.rd  = busSel && !busWr;
  assign strobe.sel = sel;

  assign txPushReq = strobe.wr && (sel == SEL_DATA);
  assign rxPopReq  = strobe.rd && (sel == SEL_DATA);

endmodule

// File: rtl/uart_regif_dp.sv
module uart_regif_dp
  import uart_regif_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [CW-1:0]     txCnt,
  input  logic [CW-1:0]     rxCnt,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              rxEmpty,
  input  logic [DATA_W-1:0] rxHead,
  input  logic              rxPush,
  input  logic [2:0]        rxErr,
  input  logic              rxTimeout,
  input  logic              txShifting,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  output logic [6:0]        lineCfg,
  output logic [15:0]       baudDiv,
  output logic              uartEn,
  output logic              loopback,
  output logic              irq
);

  logic [3:0]    statReg;
  logic [6:0]    lineReg;
  logic [7:0]    baudHi;
  logic [7:0]    baudLo;
  logic [7:0]    ctrlReg;
  logic [3:0]    iirReg;
  logic [CW-1:0] rxLvl;
  logic [CW-1:0] txLvl;
  logic [2:0]    mS1;
  logic [2:0]    mS2;
  logic          ctsS3;
  logic [7:0]    flags;
  logic [3:0]    statSet;
  logic [3:0]    iirSet;
  logic          statClr;
  logic          iirClr;
  logic [31:0]   rdVal;

  // modem line synchroniser, mS2 order {dcd, dsr, cts}
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1   <= '0;
      mS2   <= '0;
      ctsS3 <= 1'b0;
    end else begin
      mS1   <= {dcdIn, dsrIn, ctsIn};
      mS2   <= mS1;
      ctsS3 <= mS2[0];
    end
  end

  assign flags = {txEmpty, rxFull, txFull, rxEmpty,
                  (!txEmpty || txShifting), mS2[2], mS2[1], mS2[0]};

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineReg <= '0;
      baudHi  <= '0;
      baudLo  <= '0;
      ctrlReg <= '0;
      rxLvl   <= '0;
      txLvl   <= '0;
    end else if (strobe.wr) begin
      case (strobe.sel)
        SEL_LINE:  lineReg <= busWdata[6:0];
        SEL_BAUDH: baudHi  <= busWdata[7:0];
        SEL_BAUDL: baudLo  <= busWdata[7:0];
        SEL_CTRL:  ctrlReg <= busWdata[7:0] & 8'hF9;
        SEL_RXLVL: rxLvl   <= busWdata[CW-1:0];
        SEL_TXLVL: txLvl   <= busWdata[CW-1:0];
        default:   ;
      endcase
    end
  end

  // sticky receive error capture
  assign statClr = strobe.wr && (strobe.sel == SEL_STAT);
  assign statSet = {rxPush && rxFull, rxPush ? rxErr : 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        statReg <= '0;
    else if (statClr) statReg <= '0;
    else              statReg <= statReg | statSet;
  end

  // interrupt sources
  always_comb begin
    iirSet = '0;
    iirSet[IRQ_MODEM] = ctrlReg[CTRL_MSIE] && (mS2[0] != ctsS3);
    iirSet[IRQ_RX]    = ctrlReg[CTRL_RXIE] && (rxCnt >= rxLvl);
    iirSet[IRQ_TX]    = ctrlReg[CTRL_TXIE] && (txCnt <= txLvl);
    iirSet[IRQ_TOUT]  = ctrlReg[CTRL_TOIE] && rxTimeout;
  end

  assign iirClr = strobe.wr && (strobe.sel == SEL_IIR) && (busWdata == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       iirReg <= '0;
    else if (iirClr) iirReg <= '0;
    else             iirReg <= iirReg | iirSet;
  end

  // read path
  always_comb begin
    rdVal = '0;
    case (strobe.sel)
      SEL_DATA:  rdVal[DATA_W-1:0] = rxEmpty ? '0 : rxHead;
      SEL_STAT:  rdVal[3:0]    = statReg;
      SEL_LINE:  rdVal[6:0]    = lineReg;
      SEL_BAUDH: rdVal[7:0]    = baudHi;
      SEL_BAUDL: rdVal[7:0]    = baudLo;
      SEL_CTRL:  rdVal[7:0]    = ctrlReg;
      SEL_FLAG:  rdVal[7:0]    = flags;
      SEL_IIR:   rdVal[3:0]    = iirReg;
      SEL_RXLVL: rdVal[CW-1:0] = rxLvl;
      SEL_TXLVL: rdVal[CW-1:0] = txLvl;
      default:   rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busRdata <= '0;
    else if (strobe.rd) busRdata <= rdVal;
  end

  assign lineCfg  = lineReg;
  assign baudDiv  = {baudHi, baudLo};
  assign uartEn   = ctrlReg[CTRL_EN];
  assign loopback = ctrlReg[CTRL_LOOP];
  assign irq      = |iirReg;

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [DATA_W-1:0] txData,
  output logic              txEmpty,
  input  logic              txPop,
  input  logic              txShifting,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxPush,
  input  logic [2:0]        rxErr,
  input  logic              rxTimeout,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  output logic [6:0]        lineCfg,
  output logic [15:0]       baudDiv,
  output logic              uartEn,
  output logic              loopback,
  output logic              irq
);

  busStrobe_t        strobe;
  logic              txPushReq;
  logic              rxPopReq;
  logic [CW-1:0]     txCnt;
  logic [CW-1:0]     rxCnt;
  logic              txFull;
  logic              rxFull;
  logic              rxEmpty;
  logic [DATA_W-1:0] rxHead;

  uart_regif_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .strobe    (strobe),
    .txPushReq (txPushReq),
    .rxPopReq  (rxPopReq)
  );

  uart_regif_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_txFifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (txPushReq),
    .pop   (txPop),
    .wdata (busWdata[DATA_W-1:0]),
    .head  (txData),
    .count (txCnt),
    .full  (txFull),
    .empty (txEmpty)
  );

  uart_regif_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rxFifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (rxPush),
    .pop   (rxPopReq),
    .wdata (rxData),
    .head  (rxHead),
    .count (rxCnt),
    .full  (rxFull),
    .empty (rxEmpty)
  );

  uart_regif_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .txCnt      (txCnt),
    .rxCnt      (rxCnt),
    .txFull     (txFull),
    .txEmpty    (txEmpty),
    .rxFull     (rxFull),
    .rxEmpty    (rxEmpty),
    .rxHead     (rxHead),
    .rxPush     (rxPush),
    .rxErr      (rxErr),
    .rxTimeout  (rxTimeout),
    .txShifting (txShifting),
    .ctsIn      (ctsIn),
    .dsrIn      (dsrIn),
    .dcdIn      (dcdIn),
    .lineCfg    (lineCfg),
    .baudDiv    (baudDiv),
    .uartEn     (uartEn),
    .loopback   (loopback),
    .irq        (irq)
  );

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int WW = ADDR_W - 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              irq,
  input logic              txPop,
  input logic              rxPush,
  input logic [CW-1:0]     txCnt,
  input logic [CW-1:0]     rxCnt
);

  logic [WW-1:0] word;
  logic          dataWr;
  logic          dataRd;

  assign word   = busAddr[ADDR_W-1:2];
  assign dataWr = busSel && busWr && (word == WW'(0));
  assign dataRd = busSel && !busWr && (word == WW'(0));

  // R11
  iir_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && (word == WW'(7)) && (busWdata == 32'h0)) |=> !irq);

  // R3
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && (rxCnt == '0)) |=> (busRdata == 32'h0));

  // R2
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((txCnt == CW'(DEPTH)) && !txPop) |=> (txCnt == CW'(DEPTH)));

  // R2
  tx_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && (txCnt != '0) && !dataWr) |=> (txCnt == $past(txCnt) - 1'b1));

  // R3
  rx_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && (rxCnt != CW'(DEPTH)) && !dataRd) |=> (rxCnt == $past(rxCnt) + 1'b1));

  // R3
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt <= CW'(DEPTH));

endmodule

bind uart_regif uart_regif_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irq      (irq),
  .txPop    (txPop),
  .rxPush   (rxPush),
  .txCnt    (txCnt),
  .rxCnt    (rxCnt)
);

// File: tb/uart_regif_test.sv
module uart_regif_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  localparam logic [5:0] A_DATA = 6'h00, A_STAT = 6'h04, A_LINE = 6'h08,
                         A_BH = 6'h0C, A_BL = 6'h10, A_CTRL = 6'h14,
                         A_FLAG = 6'h18, A_IIR = 6'h1C, A_RXL = 6'h38,
                         A_TXL = 6'h3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  txData;
  logic        txEmpty;
  logic        txPop = 1'b0;
  logic        txShifting = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxPush = 1'b0;
  logic [2:0]  rxErr = '0;
  logic        rxTimeout = 1'b0;
  logic        ctsIn = 1'b0;
  logic        dsrIn = 1'b0;
  logic        dcdIn = 1'b0;
  logic [6:0]  lineCfg;
  logic [15:0] baudDiv;
  logic        uartEn;
  logic        loopback;
  logic        irq;

  int  errors = 0;
  int  checks = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_regif uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txData(txData), .txEmpty(txEmpty), .txPop(txPop),
    .txShifting(txShifting), .rxData(rxData), .rxPush(rxPush),
    .rxErr(rxErr), .rxTimeout(rxTimeout), .ctsIn(ctsIn), .dsrIn(dsrIn),
    .dcdIn(dcdIn), .lineCfg(lineCfg), .baudDiv(baudDiv), .uartEn(uartEn),
    .loopback(loopback), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic [3:0]  mStat, mIir;
  logic [6:0]  mLine;
  logic [7:0]  mBh, mBl, mCtrl;
  int          mRxl, mTxl;
  logic [31:0] mRdata;
  logic [2:0]  m1, m2;
  logic        m3;

  function automatic logic [31:0] modelRead(input logic [3:0] w);
    logic [31:0] v;
    v = '0;
    case (w)
      4'd0:  v = (rxq.size() == 0) ? 32'h0 : {24'h0, rxq[0]};
      4'd1:  v = {28'h0, mStat};
      4'd2:  v = {25'h0, mLine};
      4'd3:  v = {24'h0, mBh};
      4'd4:  v = {24'h0, mBl};
      4'd5:  v = {24'h0, mCtrl};
      4'd6:  v = {24'h0, txq.size() == 0, rxq.size() == DEPTH, txq.size() == DEPTH,
                  rxq.size() == 0, (txq.size() != 0) || txShifting, m2[2], m2[1], m2[0]};
      4'd7:  v = {28'h0, mIir};
      4'd14: v = 32'(mRxl);
      4'd15: v = 32'(mTxl);
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      txq.delete(); rxq.delete();
      mStat = '0; mIir = '0; mLine = '0; mBh = '0; mBl = '0; mCtrl = '0;
      mRxl = 0; mTxl = 0; mRdata = '0; m1 = '0; m2 = '0; m3 = 1'b0;
    end else begin
      int oTx, oRx;
      logic [3:0] iset;
      logic [3:0] w;
      logic dataW, dataR;
      oTx = txq.size(); oRx = rxq.size();
      w = busAddr[5:2];
      iset = {mCtrl[6] && rxTimeout, mCtrl[5] && (oTx <= mTxl),
              mCtrl[4] && (oRx >= mRxl), mCtrl[3] && (m2[0] != m3)};
      dataW = busSel && busWr && (w == 4'd0);
      dataR = busSel && !busWr && (w == 4'd0);
      if (busSel && !busWr) mRdata = modelRead(w);
      // transmit queue
      if (txPop && oTx > 0) void'(txq.pop_front());
      if (dataW && oTx < DEPTH) txq.push_back(busWdata[7:0]);
      // receive queue and status
      if (dataR && oRx > 0) void'(rxq.pop_front());
      if (busSel && busWr && w == 4'd1) mStat = '0;
      else if (rxPush) mStat = mStat | {oRx == DEPTH, rxErr};
      if (rxPush && oRx < DEPTH) rxq.push_back(rxData);
      // configuration
      if (busSel && busWr) begin
        case (w)
          4'd2:  mLine = busWdata[6:0];
          4'd3:  mBh = busWdata[7:0];
          4'd4:  mBl = busWdata[7:0];
          4'd5:  mCtrl = busWdata[7:0] & 8'hF9;
          4'd14: mRxl = int'(busWdata[4:0]);
          4'd15: mTxl = int'(busWdata[4:0]);
          default: ;
        endcase
      end
      if (busSel && busWr && w == 4'd7 && busWdata == 0) mIir = '0;
      else mIir = mIir | iset;
      m3 = m2[0]; m2 = m1; m1 = {dcdIn, dsrIn, ctsIn};
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2 txEmpty", {31'h0, txEmpty}, {31'h0, txq.size() == 0});
      if (txq.size() != 0) check("R2 txData", {24'h0, txData}, {24'h0, txq[0]});
      check("R3 busRdata", busRdata, mRdata);
      check("R11 irq", {31'h0, irq}, {31'h0, |mIir});
      check("R5 lineCfg", {25'h0, lineCfg}, {25'h0, mLine});
      check("R5 baudDiv", {16'h0, baudDiv}, {16'h0, mBh, mBl});
      check("R5 uartEn", {30'h0, uartEn, loopback}, {30'h0, mCtrl[0], mCtrl[7]});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic rxIn(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk);
    rxPush = 1'b1; rxData = d; rxErr = e;
    @(negedge clk);
    rxPush = 1'b0; rxErr = '0;
  endtask

  task automatic txTake();
    @(negedge clk);
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int pops;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    busRead(A_FLAG, v); check("R1 flags after reset", v, 32'h90);
    busRead(A_LINE, v); check("R1 line after reset", v, 32'h0);
    busRead(A_IIR, v);  check("R1 iir after reset", v, 32'h0);

    // R5 configuration
    busWrite(A_LINE, 32'hFFFF_FF6B); busRead(A_LINE, v); check("R5 line readback", v, 32'h6B);
    check("R5 lineCfg pins", {25'h0, lineCfg}, 32'h6B);
    busWrite(A_BH, 32'h112); busWrite(A_BL, 32'h34);
    check("R5 baudDiv", {16'h0, baudDiv}, 32'h1234);
    busWrite(A_CTRL, 32'h87); busRead(A_CTRL, v); check("R5 ctrl mask", v, 32'h81);
    check("R5 uartEn loopback", {30'h0, uartEn, loopback}, 32'h3);

    // R2 transmit FIFO fill, overflow ignored, order
    for (int i = 0; i < 18; i++) busWrite(A_DATA, 32'hA00 + i);
    busRead(A_FLAG, v); check("R2 tx full flag", v & 32'hA8, 32'h28);
    check("R2 head", {24'h0, txData}, 32'h00);
    pops = 0;
    while (!txEmpty && pops < 40) begin
      check("R2 order", {24'h0, txData}, 32'(pops));
      txTake(); pops++;
    end
    check("R2 overflow dropped", 32'(pops), 32'd16);

    // R12 busy while shifting
    txShifting = 1'b1; busRead(A_FLAG, v); check("R12 busy shifting", v & 32'h08, 32'h08);
    txShifting = 1'b0; busRead(A_FLAG, v); check("R12 idle", v & 32'h08, 32'h00);

    // R3 and R4 receive path
    rxIn(8'h41, 3'b001); rxIn(8'h42, 3'b010); rxIn(8'h43, 3'b000);
    busRead(A_STAT, v); check("R4 frame parity", v, 32'h3);
    busRead(A_DATA, v); check("R3 first", v, 32'h41);
    busRead(A_DATA, v); check("R3 second", v, 32'h42);
    busRead(A_DATA, v); check("R3 third", v, 32'h43);
    busRead(A_DATA, v); check("R3 empty read", v, 32'h0);
    busRead(A_FLAG, v); check("R3 still empty", v & 32'h10, 32'h10);
    busWrite(A_STAT, 32'h0); busRead(A_STAT, v); check("R4 clear", v, 32'h0);
    for (int i = 0; i < 17; i++) rxIn(8'(i), 3'b000);
    busRead(A_STAT, v); check("R4 overrun", v, 32'h8);
    busRead(A_FLAG, v); check("R6 rx full flag", v & 32'h50, 32'h40);
    rxIn(8'h77, 3'b100);
    busRead(A_STAT, v); check("R4 break sticky", v, 32'hC);
    busWrite(A_STAT, 32'h5A); busRead(A_STAT, v); check("R4 any write clears", v, 32'h0);
    for (int i = 0; i < 16; i++) begin
      busRead(A_DATA, v); check("R3 drain order", v, 32'(i));
    end

    // R7 receive threshold
    busWrite(A_RXL, 32'd4); busWrite(A_CTRL, 32'h10); busWrite(A_IIR, 32'h0);
    rxIn(8'h1, 3'b0); rxIn(8'h2, 3'b0); rxIn(8'h3, 3'b0);
    idle(2); check("R7 below level", {31'h0, irq}, 32'h0);
    rxIn(8'h4, 3'b0); idle(1);
    check("R7 at level", {31'h0, irq}, 32'h1);
    busRead(A_IIR, v); check("R7 iir rx", v, 32'h2);
    for (int i = 0; i < 4; i++) busRead(A_DATA, v);

    // R8 transmit threshold
    busWrite(A_TXL, 32'd2); busWrite(A_CTRL, 32'h20); busWrite(A_IIR, 32'h0);
    idle(1); busRead(A_IIR, v); check("R8 iir tx", v, 32'h4);
    busWrite(A_DATA, 32'h1); busWrite(A_DATA, 32'h2); busWrite(A_DATA, 32'h3);
    busWrite(A_IIR, 32'h0); idle(2); check("R8 above level", {31'h0, irq}, 32'h0);
    txTake(); idle(1); check("R8 at level", {31'h0, irq}, 32'h1);
    for (int i = 0; i < 2; i++) txTake();

    // R9 modem change and R6 modem flags
    busWrite(A_CTRL, 32'h08); busWrite(A_IIR, 32'h0); idle(2);
    check("R9 quiet", {31'h0, irq}, 32'h0);
    ctsIn = 1'b1; idle(4);
    busRead(A_IIR, v); check("R9 cts change", v, 32'h1);
    dsrIn = 1'b1; dcdIn = 1'b1; idle(3);
    busRead(A_FLAG, v); check("R6 modem flags", v & 32'h07, 32'h07);

    // R10 timeout and R11 clear rules
    busWrite(A_CTRL, 32'h40); busWrite(A_IIR, 32'h0); idle(2);
    @(negedge clk) rxTimeout = 1'b1;
    @(negedge clk) rxTimeout = 1'b0;
    busRead(A_IIR, v); check("R10 timeout", v, 32'h8);
    busWrite(A_IIR, 32'hF); busRead(A_IIR, v); check("R11 nonzero write", v, 32'h8);
    busWrite(A_IIR, 32'h0); check("R11 cleared", {31'h0, irq}, 32'h0);
    busWrite(A_CTRL, 32'h0); busRead(6'h24, v); check("R5 unmapped", v, 32'h0);

    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule